// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the device-side status and protection path of a serial flash that answers in SPI mode 0. A system clock oversamples the chip-select, serial clock and serial data inputs. The block shifts in 8-bit opcodes, MSB first, and keeps three status bytes. It also holds a write-enable latch and a write-in-progress flag. It answers status reads and status writes, runs a timed busy cycle after each non-volatile status write, and obeys a write-protect pin. It has a deep power-down state that blocks every opcode except the one that wakes it.

A level input, `pgmEraseEn`, makes the block respond to program and erase opcodes. The only effect of those opcodes here is to drop the write-enable latch. There is no memory array behind the block. The length of the busy cycle is a parameter counted in system clocks. SO is modelled as a data output plus an output-enable, so a pad ring can build the tri-state driver.

Top module: `sreg_top`

## Requirements
- R1: After reset, all 24 status bits read as 0 and `soOe` is low.
- R2: Opcode 06h sets the write-enable latch (WEL, status bit 1) and opcode 04h clears it. Each acts when its eighth opcode bit is latched.
- R3: While `pgmEraseEn` is high, opcodes 02h, 20h, 52h, D8h, 60h and C7h clear WEL. While it is low, they have no effect.
- R4: Opcodes 01h, 31h and 11h write status byte 0, 1 and 2. Such a write is ignored unless WEL was set, or a 50h opcode armed it, when the opcode arrived.
- R5: A status write takes effect only if CS# rises after exactly 8 data bits. With 7 or 9 data bits nothing changes.
- R6: A committed non-volatile write sets WIP (status bit 0) for TW_CYCLES clocks. When WIP falls, WEL is clear.
- R7: Opcodes 05h, 35h and 15h return status byte 0, 1 and 2. The data is MSB first, changes after falling SCLK, repeats while CS# stays low, and shows the live value, including WIP, during a busy cycle.
- R8: Status bits 23, 20..16, 15, 10, 1 and 0 never change through a status write.
- R9: While `wpN` is low, bits 7..2 and bit 8 are frozen against status writes.
- R10: Opcode B9h enters deep power-down. In that state, every opcode except ABh is ignored (no SO drive, no WEL change), and ABh leaves the state.
- R11: While WIP is 1, every opcode other than a status read is ignored.
- R12: Opcode 50h arms a volatile write. The next accepted opcode consumes the arm. If that opcode is a status write, it commits with no busy cycle and leaves WEL unchanged.
- R13: `soOe` is high only while status data is being shifted out, never during the opcode or while CS# is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset (power-up) |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idle low (mode 0) |
| si | input | 1 | Serial data in, sampled on rising SCLK |
| wpN | input | 1 | Write-protect pin, active low, treated as quasi-static |
| pgmEraseEn | input | 1 | Lets program and erase opcodes clear WEL |
| soData | output | 1 | Serial data out value |
| soOe | output | 1 | Output enable for serial data out |

## Verification
The bench builds the block with TW_CYCLES set to 800. This keeps the busy window long enough that a WRDI, a power-down request and a two-byte status read all fit inside it, and short enough that the full write sweep finishes quickly. With that setting, every writable status byte is swept through eight data patterns under both levels of the write-protect pin, and each result is compared with a mask model. Commit edges at 7, 8 and 9 data bits, the volatile-write arm and its consumption, and power-down gating are each driven on their own.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_VWREN = 8'h50;
  localparam logic [7:0] OP_RD0   = 8'h05;
  localparam logic [7:0] OP_RD1   = 8'h35;
  localparam logic [7:0] OP_RD2   = 8'h15;
  localparam logic [7:0] OP_WR0   = 8'h01;
  localparam logic [7:0] OP_WR1   = 8'h31;
  localparam logic [7:0] OP_WR2   = 8'h11;
  localparam logic [7:0] OP_PGM   = 8'h02;
  localparam logic [7:0] OP_ER4K  = 8'h20;
  localparam logic [7:0] OP_ER32K = 8'h52;
  localparam logic [7:0] OP_ER64K = 8'hD8;
  localparam logic [7:0] OP_ERALL = 8'h60;
  localparam logic [7:0] OP_ERAL2 = 8'hC7;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;

  // bits a status write may change, and bits the protect pin freezes
  localparam logic [23:0] WR_MASK   = 24'h607BFC;
  localparam logic [23:0] WP_FREEZE = 24'h0001FC;

  typedef enum logic [1:0] {ST_OPC, ST_READ, ST_WDATA, ST_SKIP} spiState_t;

  typedef struct packed {
    logic       setWel;
    logic       clrWel;
    logic       commitNv;
    logic       commitVol;
    logic       enterDpd;
    logic       exitDpd;
    logic [1:0] sel;
    logic [7:0] data;
  } ctlStrobe_t;

  function automatic logic [7:0] byteOf(input logic [23:0] v, input logic [1:0] sel);
    case (sel)
      2'd1:    return v[15:8];
      2'd2:    return v[23:16];
      default: return v[7:0];
    endcase
  endfunction

endpackage

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       si,
  input  logic       pgmEraseEn,
  input  logic       wel,
  input  logic       wip,
  input  logic       dpd,
  input  logic [7:0] rdByte,
  output logic [1:0] rdSel,
  output ctlStrobe_t stb,
  output logic       csHigh,
  output logic       soData,
  output logic       soOe
);

  logic [1:0] csS;
  logic [2:0] sclkS;
  logic [1:0] siS;
  logic       csPrev;
  spiState_t  st;
  logic [3:0] bitCnt;
  logic [7:0] shiftIn;
  logic [2:0] outCnt;
  logic [1:0] wrSel;
  logic       wrVol;
  logic       volArm;

  logic       sclkRise, sclkFall, csRise, opcDone;
  logic [7:0] opcNext;
  logic       isRead, isWrite, isPgm, allowed;
  logic [1:0] selNext;

  assign csHigh   = csS[1];
  assign sclkRise = sclkS[1] & ~sclkS[2];
  assign sclkFall = ~sclkS[1] & sclkS[2];
  assign csRise   = csHigh & ~csPrev;
  assign opcNext  = {shiftIn[6:0], siS[1]};
  assign opcDone  = !csHigh && st == ST_OPC && sclkRise && bitCnt == 4'd7;

  always_comb begin
    isRead  = opcNext inside {OP_RD0, OP_RD1, OP_RD2};
    isWrite = opcNext inside {OP_WR0, OP_WR1, OP_WR2};
    isPgm   = opcNext inside {OP_PGM, OP_ER4K, OP_ER32K, OP_ER64K, OP_ERALL, OP_ERAL2};
    case (opcNext)
      OP_RD1, OP_WR1: selNext = 2'd1;
      OP_RD2, OP_WR2: selNext = 2'd2;
      default:        selNext = 2'd0;
    endcase
    allowed = dpd ? (opcNext == OP_WAKE) : (!wip || isRead);
  end

  always_comb begin
    stb = '0;
    if (opcDone && allowed) begin
      stb.setWel   = opcNext == OP_WREN;
      stb.clrWel   = opcNext == OP_WRDI || (pgmEraseEn && isPgm);
      stb.enterDpd = opcNext == OP_SLEEP;
      stb.exitDpd  = opcNext == OP_WAKE;
    end
    if (csRise && st == ST_WDATA && bitCnt == 4'd8) begin
      stb.commitVol = wrVol;
      stb.commitNv  = !wrVol;
    end
    stb.sel  = wrSel;
    stb.data = shiftIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csS     <= 2'b11;
      sclkS   <= '0;
      siS     <= '0;
      csPrev  <= 1'b1;
      st      <= ST_OPC;
      bitCnt  <= '0;
      shiftIn <= '0;
      outCnt  <= '0;
      rdSel   <= '0;
      wrSel   <= '0;
      wrVol   <= 1'b0;
      volArm  <= 1'b0;
      soData  <= 1'b0;
      soOe    <= 1'b0;
    end else begin
      csS    <= {csS[0], csN};
      sclkS  <= {sclkS[1:0], sclk};
      siS    <= {siS[0], si};
      csPrev <= csHigh;
      if (csHigh) begin
        st     <= ST_OPC;
        bitCnt <= '0;
        outCnt <= '0;
        soOe   <= 1'b0;
      end else if (sclkRise) begin
        if (st == ST_OPC) begin
          shiftIn <= opcNext;
          if (bitCnt == 4'd7) begin
            bitCnt <= '0;
            if (allowed) begin
              volArm <= opcNext == OP_VWREN;
              rdSel  <= selNext;
              wrSel  <= selNext;
              wrVol  <= volArm;
            end
            if (!allowed)                        st <= ST_SKIP;
            else if (isRead)                     st <= ST_READ;
            else if (isWrite && (wel || volArm)) st <= ST_WDATA;
            else                                 st <= ST_SKIP;
          end else begin
            bitCnt <= bitCnt + 4'd1;
          end
        end else if (st == ST_WDATA) begin
          shiftIn <= opcNext;
          if (bitCnt != 4'd9) bitCnt <= bitCnt + 4'd1;
        end
      end else if (sclkFall && st == ST_READ) begin
        soData <= rdByte[3'd7 - outCnt];
        outCnt <= outCnt + 3'd1;
        soOe   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sreg_datapath.sv
module sreg_datapath
  import sreg_pkg::*;
#(
  parameter int TW_CYCLES = 200000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wpN,
  input  ctlStrobe_t  stb,
  input  logic [1:0]  rdSel,
  output logic [7:0]  rdByte,
  output logic        wel,
  output logic        wip,
  output logic        dpd,
  output logic [23:0] statQ
);

  localparam int CNT_W = $clog2(TW_CYCLES + 1);

  logic [CNT_W-1:0] twCnt;
  logic [23:0]      laneMask, bitMask, newVal;

  always_comb begin
    case (stb.sel)
      2'd1:    laneMask = 24'h00FF00;
      2'd2:    laneMask = 24'hFF0000;
      default: laneMask = 24'h0000FF;
    endcase
    bitMask = laneMask & WR_MASK & (wpN ? 24'hFFFFFF : ~WP_FREEZE);
    newVal  = (statQ & ~bitMask) | ({3{stb.data}} & bitMask);
    rdByte  = byteOf({statQ[23:2], wel, wip}, rdSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
      wel   <= 1'b0;
      wip   <= 1'b0;
      dpd   <= 1'b0;
      twCnt <= '0;
    end else begin
      if (stb.commitNv || stb.commitVol) statQ <= newVal;
      if (stb.enterDpd) dpd <= 1'b1;
      else if (stb.exitDpd) dpd <= 1'b0;
      if (stb.commitNv) begin
        wip   <= 1'b1;
        twCnt <= CNT_W'(TW_CYCLES - 1);
      end else if (wip) begin
        if (twCnt == '0) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end else begin
          twCnt <= twCnt - 1'b1;
        end
      end
      if (stb.setWel) wel <= 1'b1;
      else if (stb.clrWel) wel <= 1'b0;
    end
  end

endmodule

// File: rtl/sreg_top.sv
module sreg_top
  import sreg_pkg::*;
#(
  parameter int TW_CYCLES = 200000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic si,
  input  logic wpN,
  input  logic pgmEraseEn,
  output logic soData,
  output logic soOe
);

  ctlStrobe_t  stb;
  logic [1:0]  rdSel;
  logic [7:0]  rdByte;
  logic        wel, wip, dpd, csHigh;
  logic [23:0] statQ;

  sreg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .si(si),
    .pgmEraseEn(pgmEraseEn), .wel(wel), .wip(wip), .dpd(dpd),
    .rdByte(rdByte), .rdSel(rdSel), .stb(stb), .csHigh(csHigh),
    .soData(soData), .soOe(soOe)
  );

  sreg_datapath #(.TW_CYCLES(TW_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .wpN(wpN), .stb(stb), .rdSel(rdSel),
    .rdByte(rdByte), .wel(wel), .wip(wip), .dpd(dpd), .statQ(statQ)
  );

endmodule

// File: rtl/sreg_checker.sv
module sreg_checker
  import sreg_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wpN,
  input logic        csHigh,
  input logic        soOe,
  input logic        wel,
  input logic        wip,
  input logic        dpd,
  input logic [23:0] statQ
);

  localparam logic [23:0] FIXED = ~WR_MASK & 24'hFFFFFC;

  a_r6_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);

  a_r13_oe_off_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    $past(csHigh) |-> !soOe);

  a_r8_fixed_bits: assert property (@(posedge clk) disable iff (!rstN)
    $stable(statQ & FIXED));

  a_r9_wp_freeze: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wpN) |-> $stable(statQ & WP_FREEZE));

  a_r11_busy_no_sleep: assert property (@(posedge clk) disable iff (!rstN)
    $past(wip) |-> $stable(dpd));

  a_r10_sleep_keeps_wel: assert property (@(posedge clk) disable iff (!rstN)
    $past(dpd) |-> $stable(wel));

endmodule

bind sreg_top sreg_checker chk_i (
  .clk(clk), .rstN(rstN), .wpN(wpN), .csHigh(csHigh), .soOe(soOe),
  .wel(wel), .wip(wip), .dpd(dpd), .statQ(statQ)
);

// File: tb/sreg_top_tb_top.sv
module sreg_top_tb_top;

  localparam int TW = 800;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, si = 1'b0, wpN = 1'b1, pgmEraseEn = 1'b1;
  logic soData, soOe;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [7:0] expS [3];
  logic       expWel;
  logic [7:0] b0, b1;
  logic       oeOp, oeData;

  always #10 clk = ~clk;

  sreg_top #(.TW_CYCLES(TW)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .si(si), .wpN(wpN),
    .pgmEraseEn(pgmEraseEn), .soData(soData), .soOe(soOe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bitIo(input logic b, output logic r, output logic oe);
    @(negedge clk); si = b; sclk = 1'b0;
    repeat (H) @(negedge clk);
    sclk = 1'b1;
    repeat (H - 1) @(negedge clk);
    r = soData; oe = soOe;
  endtask

  task automatic sendBits(input logic [7:0] v, input int n, output logic [7:0] rd,
                          output logic oeAll, output logic oeAny);
    logic r, oe;
    rd = '0; oeAll = 1'b1; oeAny = 1'b0;
    for (int i = 0; i < n; i++) begin
      bitIo(v[7 - i], r, oe);
      rd = {rd[6:0], r};
      oeAll &= oe; oeAny |= oe;
    end
  endtask

  task automatic csStart();
    @(negedge clk); csN = 1'b0; sclk = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic csEnd();
    @(negedge clk); sclk = 1'b0;
    repeat (H) @(negedge clk);
    csN = 1'b1;
    repeat (3 * H) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d; logic a, y;
    csStart(); sendBits(op, 8, d, a, y); csEnd();
  endtask

  task automatic rdStat(input logic [7:0] op);
    logic a, y1, y2;
    csStart();
    sendBits(op, 8, b0, a, oeOp);
    sendBits(8'h00, 8, b0, oeData, y1);
    sendBits(8'h00, 8, b1, a, y2);
    oeData &= a;
    csEnd();
  endtask

  task automatic wrStat(input logic [7:0] op, input logic [7:0] d, input int n);
    logic [7:0] x; logic a, y;
    csStart();
    sendBits(op, 8, x, a, y);
    if (n <= 8) sendBits(d, n, x, a, y);
    else begin
      sendBits(d, 8, x, a, y);
      sendBits(8'h00, n - 8, x, a, y);
    end
    csEnd();
  endtask

  function automatic logic [7:0] wrMask(input int k, input logic wp);
    logic [7:0] m, f;
    m = (k == 0) ? 8'hFC : (k == 1) ? 8'h7B : 8'h60;
    f = (k == 0) ? 8'hFC : (k == 1) ? 8'h01 : 8'h00;
    return wp ? m : (m & ~f);
  endfunction

  task automatic model(input int k, input logic [7:0] d);
    logic [7:0] m;
    m = wrMask(k, wpN);
    expS[k] = (expS[k] & ~m) | (d & m);
  endtask

  function automatic logic [7:0] st0(input logic w, input logic b);
    return {expS[0][7:2], w, b};
  endfunction

  function automatic logic [7:0] rdOp(input int k);
    return (k == 0) ? 8'h05 : (k == 1) ? 8'h35 : 8'h15;
  endfunction

  function automatic logic [7:0] wrOp(input int k);
    return (k == 0) ? 8'h01 : (k == 1) ? 8'h31 : 8'h11;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    expS[0] = '0; expS[1] = '0; expS[2] = '0; expWel = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state and idle output enable (R13)
    chk("R1 soOe idle", {7'd0, soOe}, 8'h00);
    for (int k = 0; k < 3; k++) begin
      rdStat(rdOp(k));
      chk("R1 reset byte", b0, 8'h00);
      chk("R13 oe during opcode", {7'd0, oeOp}, 8'h00);
      chk("R7 oe during data", {7'd0, oeData}, 8'h01);
    end

    // R2 set and clear WEL
    cmd(8'h06); rdStat(8'h05);
    chk("R2 wren", b0, st0(1'b1, 1'b0));
    cmd(8'h04); rdStat(8'h05);
    chk("R2 wrdi", b0, st0(1'b0, 1'b0));

    // R8 R9 sweep over bytes, protect levels and data patterns
    for (int k = 0; k < 3; k++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 8; i++) begin
          logic [7:0] d;
          d = (i == 0) ? 8'hFF : (i == 1) ? 8'h00 : (8'(i * 73) ^ 8'h5A);
          wpN = w[0];
          cmd(8'h06);
          wrStat(wrOp(k), d, 8);
          model(k, d);
          repeat (TW + 50) @(negedge clk);
          rdStat(rdOp(k));
          if (k == 0) begin
            chk(w == 0 ? "R9 byte0 frozen" : "R8 byte0 mask", b0, st0(1'b0, 1'b0));
            chk("R7 repeat byte0", b1, st0(1'b0, 1'b0));
          end else begin
            chk(w == 0 ? "R9 byte frozen" : "R8 byte mask", b0, expS[k]);
            chk("R7 repeat byte", b1, expS[k]);
          end
        end
    wpN = 1'b1;

    // R6 R7 R11 busy window: WRDI and sleep ignored, live WIP read
    cmd(8'h06);
    wrStat(8'h31, 8'h2C, 8); model(1, 8'h2C);
    cmd(8'h04);
    cmd(8'hB9);
    rdStat(8'h05);
    chk("R11 busy wel kept", b0, st0(1'b1, 1'b1));
    chk("R6 wip high repeat", b1, st0(1'b1, 1'b1));
    repeat (TW + 50) @(negedge clk);
    rdStat(8'h05);
    chk("R6 wip and wel cleared", b0, st0(1'b0, 1'b0));
    chk("R11 sleep not entered", {7'd0, oeData}, 8'h01);
    rdStat(8'h35);
    chk("R4 byte1 written", b0, expS[1]);

    // R5 commit boundaries: 7 and 9 data bits discarded
    cmd(8'h06);
    wrStat(8'h31, ~expS[1], 7);
    wrStat(8'h31, ~expS[1], 9);
    rdStat(8'h35);
    chk("R5 off-boundary discarded", b0, expS[1]);
    rdStat(8'h05);
    chk("R5 no busy and wel kept", b0, st0(1'b1, 1'b0));

    // R4 write without WEL ignored
    cmd(8'h04);
    wrStat(8'h31, ~expS[1], 8);
    rdStat(8'h05);
    chk("R4 no wel no busy", b0, st0(1'b0, 1'b0));
    rdStat(8'h35);
    chk("R4 no wel unchanged", b0, expS[1]);

    // R12 volatile write and arm consumption
    cmd(8'h50);
    wrStat(8'h31, 8'h5A, 8); model(1, 8'h5A);
    rdStat(8'h05);
    chk("R12 volatile no busy", b0, st0(1'b0, 1'b0));
    rdStat(8'h35);
    chk("R12 volatile applied", b0, expS[1]);
    cmd(8'h50);
    rdStat(8'h05);
    wrStat(8'h31, ~expS[1], 8);
    rdStat(8'h35);
    chk("R12 arm consumed", b0, expS[1]);

    // R3 program and erase opcodes
    pgmEraseEn = 1'b1;
    cmd(8'h06); cmd(8'h02); rdStat(8'h05);
    chk("R3 program clears wel", b0, st0(1'b0, 1'b0));
    cmd(8'h06); cmd(8'hD8); rdStat(8'h05);
    chk("R3 erase clears wel", b0, st0(1'b0, 1'b0));
    pgmEraseEn = 1'b0;
    cmd(8'h06); cmd(8'h20); rdStat(8'h05);
    chk("R3 disabled keeps wel", b0, st0(1'b1, 1'b0));
    cmd(8'h04);
    pgmEraseEn = 1'b1;

    // R10 deep power-down
    cmd(8'hB9);
    rdStat(8'h05);
    chk("R10 read ignored", {6'd0, oeOp, oeData}, 8'h00);
    cmd(8'h06);
    cmd(8'hAB);
    rdStat(8'h05);
    chk("R10 wren ignored", b0, st0(1'b0, 1'b0));
    chk("R10 woken", {7'd0, oeData}, 8'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule